// File: doc/BRIEF.md
# Queued Serial Peripheral Master

This block is a register-driven serial peripheral master. Software fills an eight-deep transmit queue through a small register port, then sets a start bit in the control register. The block sends every queued word on the serial clock and data-out lines. It captures the word returned on data-in for each word sent and stores it in an eight-deep receive queue. The start bit reads back as 1 while the burst runs. It drops to 0 by itself once both the transmit queue and the shift engine are empty.

The serial clock is the system clock divided by a power of two, from 4 up to 512. Clock polarity and clock phase are set independently. Word length runs from 1 to 16 bits. A programmable number of idle serial-clock periods can be placed between consecutive words. Four status flags drive a single interrupt line through individual enables: transmit queue empty, receive data ready, receive overflow and transmit overflow.

Register map (3-bit address): 0 transmit data (write pushes), 1 receive data (read pops), 2 control, 3 status, 4 interrupt enable, 5 inter-word gap. The control register bits are: bit 0 enable, bit 1 master, bit 2 clock polarity, bit 3 clock phase, bit 4 start, bits 7:5 rate, bits 11:8 word length minus one. The status and enable bits are: bit 0 transmit empty, bit 1 receive ready, bit 2 receive overflow, bit 3 transmit overflow.

Top module: `spim_fifo_ctrl`

## Requirements
- R1: After reset the control register reads 0x07E0 (rate 7, length field 7, all other bits 0), status reads 0x0001, the serial clock is low and the interrupt is low.
- R2: The transmit queue holds 8 words. A write to address 0 while the queue is full and not being popped is dropped and sets status bit 3. Writing 1 to status bit 3 clears it.
- R3: Writing 1 to control bit 4 starts a burst. The bit reads 1 while the burst runs and clears by itself only once the transmit queue is empty and the shift engine is idle.
- R4: A rate field value k in control bits 7:5 gives a serial clock period of (4 << k) system clocks.
- R5: Control bits 11:8 hold word length minus one. Each word is sent MSB first, starting at bit (length-1) of the written word. The received word is right-aligned with its upper bits zero.
- R6: The serial clock idles at control bit 2 (polarity). With control bit 3 (phase) at 0, data is sampled on the leading clock edge; with it at 1, on the trailing edge. Each word produces exactly length sampling edges.
- R7: The gap register at address 5 inserts value × divisor idle system clocks between consecutive words of a burst.
- R8: Shifting happens only while control bit 0 (enable) and control bit 1 (master) are both 1. Otherwise the serial clock holds its level and queued words stay queued.
- R9: The receive queue holds 8 words, and a read of address 1 pops the oldest one. A received word that arrives with the queue full and not being popped is dropped and sets status bit 2, which is cleared by writing 1 to it.
- R10: Status bit 0 is 1 exactly when the transmit queue is empty. Status bit 1 is 1 exactly when the receive queue holds data.
- R11: The interrupt output is the OR over status bits 3:0 of each bit ANDed with the same bit of the enable register at address 4.
- R12: A transmit write in the same cycle as the engine's pop is neither lost nor duplicated, so all words come out in write order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
Two things can happen in the same cycle: a software write to the transmit queue and the shift engine popping that queue for its next word. A receive-side push can also coincide with the queue's full boundary. The coincidence is provoked by running 1-bit words at the fastest divider while transmit writes arrive every other cycle, so the pops and the writes interleave closely. The result is judged by the order and values of the received words and by the total count of sampling edges, with data-out looped back to data-in. The full-queue boundary is judged by filling each queue past eight entries and confirming which words survive and which sticky flag is raised.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int DATA_W     = 16;
    localparam int LEN_W      = 4;
    localparam int RATE_W     = 3;
    localparam int GAP_W      = 8;
    localparam int ADDR_W     = 3;
    localparam int FIFO_DEPTH = 8;
    localparam int NFLAG      = 4;

    localparam logic [ADDR_W-1:0] A_TXD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_RXD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;
    localparam logic [ADDR_W-1:0] A_GAP  = 3'd5;

    localparam int F_TXE = 0;
    localparam int F_RXR = 1;
    localparam int F_RXO = 2;
    localparam int F_TXO = 3;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_RUN  = 2'd1,
        SH_GAP  = 2'd2
    } sh_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && ((q.cnt != CW'(DEPTH)) || do_pop);
        if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
        else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= din;
    end

    assign dout  = mem[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LEN_W,
    parameter int RW = RATE_W,
    parameter int GW = GAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          go,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [RW-1:0] rate,
    input  logic [LW-1:0] wlen_m1,
    input  logic [GW-1:0] gap,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_word,
    input  logic          miso,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_word,
    output logic          busy,
    output logic          sclk,
    output logic          mosi
);
    localparam int HALF_W = (1 << RW) + 1;
    localparam int PH_W   = LW + 1;
    localparam int GAP_CW = GW + (1 << RW) + 2;

    typedef struct packed {
        sh_state_e         state;
        logic [HALF_W-1:0] div;
        logic [PH_W-1:0]   ph;
        logic [GAP_CW-1:0] gcnt;
        logic [DW-1:0]     tsh;
        logic [DW-1:0]     rsh;
        logic              sclk;
        logic              mosi;
    } sh_t;

    sh_t q, d;
    logic [HALF_W-1:0] half_lim;
    logic [PH_W-1:0]   last_ph;
    logic [GAP_CW-1:0] gap_lim;
    logic              leading;

    always_comb begin
        half_lim = (HALF_W'(2) << rate) - HALF_W'(1);
        last_ph  = {wlen_m1, 1'b1};
        gap_lim  = ((GAP_CW'(gap) << rate) << 2) - GAP_CW'(1);
        leading  = ~q.ph[0];
        d        = q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        case (q.state)
            SH_IDLE: begin
                d.sclk = cpol;
                if (go && active && !tx_empty) begin
                    tx_pop  = 1'b1;
                    d.state = SH_RUN;
                    d.div   = '0;
                    d.ph    = '0;
                    d.rsh   = '0;
                    if (!cpha) begin
                        d.mosi = tx_word[wlen_m1];
                        d.tsh  = tx_word << 1;
                    end else begin
                        d.tsh  = tx_word;
                    end
                end
            end
            SH_RUN: begin
                if (active) begin
                    if (q.div == half_lim) begin
                        d.div  = '0;
                        d.sclk = ~q.sclk;
                        d.ph   = q.ph + 1'b1;
                        if (leading ^ cpha) begin
                            d.rsh = {q.rsh[DW-2:0], miso};
                        end else if (cpha || (q.ph != last_ph)) begin
                            d.mosi = q.tsh[wlen_m1];
                            d.tsh  = q.tsh << 1;
                        end
                        if (q.ph == last_ph) begin
                            rx_push = 1'b1;
                            d.gcnt  = '0;
                            d.state = ((gap != '0) && !tx_empty) ? SH_GAP : SH_IDLE;
                        end
                    end else begin
                        d.div = q.div + 1'b1;
                    end
                end
            end
            SH_GAP: begin
                if (active) begin
                    if (q.gcnt == gap_lim) d.state = SH_IDLE;
                    else                   d.gcnt  = q.gcnt + 1'b1;
                end
            end
            default: d.state = SH_IDLE;
        endcase
        rx_word = d.rsh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= SH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.state != SH_IDLE);
    assign sclk = q.sclk;
    assign mosi = q.mosi;
endmodule

// File: rtl/spim_fifo_ctrl.sv
module spim_fifo_ctrl
    import spim_pkg::*;
#(
    parameter int QDEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              irq
);
    typedef struct packed {
        logic              en;
        logic              master;
        logic              cpol;
        logic              cpha;
        logic              xch;
        logic [RATE_W-1:0] rate;
        logic [LEN_W-1:0]  wlen_m1;
        logic [NFLAG-1:0]  ien;
        logic [GAP_W-1:0]  gap;
        logic              rx_ovf;
        logic              tx_ovf;
    } regs_t;

    regs_t q, d;

    logic              tx_wr, tx_pop, tx_empty, tx_full;
    logic              rx_rd, rx_push, rx_empty, rx_full;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic              sh_busy, shift_active;
    logic              wr_ctrl, wr_stat, wr_ien, wr_gap;
    logic              rx_ovf_clr;
    logic [NFLAG-1:0]  stat;
    logic [DATA_W-1:0] ctrl_view;

    logic xch_q, cfg_cpol, rx_ovf_q, tx_ovf_q;
    assign xch_q    = q.xch;
    assign cfg_cpol = q.cpol;
    assign rx_ovf_q = q.rx_ovf;
    assign tx_ovf_q = q.tx_ovf;

    spim_fifo #(.W(DATA_W), .DEPTH(QDEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(DATA_W), .DEPTH(QDEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
        .pop(rx_rd), .dout(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spim_shift u_eng (
        .clk(clk), .rst_n(rst_n), .active(shift_active), .go(q.xch),
        .cpol(q.cpol), .cpha(q.cpha), .rate(q.rate), .wlen_m1(q.wlen_m1),
        .gap(q.gap), .tx_empty(tx_empty), .tx_word(tx_head), .miso(spi_miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .busy(sh_busy),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

    always_comb begin
        tx_wr        = reg_wr && (reg_addr == A_TXD);
        rx_rd        = reg_rd && (reg_addr == A_RXD);
        wr_ctrl      = reg_wr && (reg_addr == A_CTRL);
        wr_stat      = reg_wr && (reg_addr == A_STAT);
        wr_ien       = reg_wr && (reg_addr == A_IEN);
        wr_gap       = reg_wr && (reg_addr == A_GAP);
        rx_ovf_clr   = wr_stat && reg_wdata[F_RXO];
        shift_active = q.en && q.master;

        d = q;
        if (wr_ctrl) begin
            d.en      = reg_wdata[0];
            d.master  = reg_wdata[1];
            d.cpol    = reg_wdata[2];
            d.cpha    = reg_wdata[3];
            d.rate    = reg_wdata[7:5];
            d.wlen_m1 = reg_wdata[11:8];
        end
        if (wr_ctrl && reg_wdata[4])              d.xch = 1'b1;
        else if (q.xch && !sh_busy && tx_empty)   d.xch = 1'b0;
        if (wr_ien) d.ien = reg_wdata[NFLAG-1:0];
        if (wr_gap) d.gap = reg_wdata[GAP_W-1:0];

        if (rx_ovf_clr)                           d.rx_ovf = 1'b0;
        if (wr_stat && reg_wdata[F_TXO])          d.tx_ovf = 1'b0;
        if (rx_push && rx_full && !rx_rd)         d.rx_ovf = 1'b1;
        if (tx_wr && tx_full && !tx_pop)          d.tx_ovf = 1'b1;

        stat             = '0;
        stat[F_TXE]      = tx_empty;
        stat[F_RXR]      = !rx_empty;
        stat[F_RXO]      = q.rx_ovf;
        stat[F_TXO]      = q.tx_ovf;

        ctrl_view        = '0;
        ctrl_view[0]     = q.en;
        ctrl_view[1]     = q.master;
        ctrl_view[2]     = q.cpol;
        ctrl_view[3]     = q.cpha;
        ctrl_view[4]     = q.xch;
        ctrl_view[7:5]   = q.rate;
        ctrl_view[11:8]  = q.wlen_m1;

        case (reg_addr)
            A_RXD:   reg_rdata = rx_empty ? '0 : rx_head;
            A_CTRL:  reg_rdata = ctrl_view;
            A_STAT:  reg_rdata = DATA_W'(stat);
            A_IEN:   reg_rdata = DATA_W'(q.ien);
            A_GAP:   reg_rdata = DATA_W'(q.gap);
            default: reg_rdata = '0;
        endcase

        irq = |(stat & q.ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.rate    <= '1;
            q.wlen_m1 <= LEN_W'(7);
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/spim_checks.sv
module spim_checks (
    input logic clk,
    input logic rst_n,
    input logic xch,
    input logic tx_empty,
    input logic sh_busy,
    input logic sclk,
    input logic cpol,
    input logic active,
    input logic rx_ovf,
    input logic rx_ovf_clr,
    input logic tx_wr,
    input logic tx_full,
    input logic tx_pop,
    input logic tx_ovf
);
    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xch) |-> ($past(tx_empty) && !$past(sh_busy)));

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_busy && !$past(sh_busy)) |-> (sclk == $past(cpol)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && sh_busy) |=> $stable(sclk));

    // R9
    rx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !rx_ovf_clr) |=> rx_ovf);

    // R2
    tx_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full && !tx_pop) |=> tx_ovf);
endmodule

bind spim_fifo_ctrl spim_checks u_chk (
    .clk(clk), .rst_n(rst_n), .xch(xch_q), .tx_empty(tx_empty),
    .sh_busy(sh_busy), .sclk(spi_sclk), .cpol(cfg_cpol), .active(shift_active),
    .rx_ovf(rx_ovf_q), .rx_ovf_clr(rx_ovf_clr), .tx_wr(tx_wr),
    .tx_full(tx_full), .tx_pop(tx_pop), .tx_ovf(tx_ovf_q)
);

// File: tb/sim_spim_fifo_ctrl.sv
`timescale 1ns/1ps
module sim_spim_fifo_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso, irq;

    int checks = 0;
    int fails  = 0;

    logic [15:0] wq [16];
    bit          b_cpol = 0, b_cpha = 0, b_en = 1, b_ms = 1;
    logic [2:0]  b_rate = 3'd7;
    logic [3:0]  b_lm = 4'd7;

    int cyc = 0, min_per = 0, max_gap = 0, last_lead = -1, last_edge = -1;
    int edges = 0, mon_bits = 0;
    logic sclk_prev = 1'b0;

    always #2.5 clk = ~clk;
    assign spi_miso = spi_mosi;

    spim_fifo_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (spi_sclk !== sclk_prev) begin
            edges = edges + 1;
            if (sclk_prev == b_cpol) begin
                if (last_lead >= 0 && (cyc - last_lead) < min_per) min_per = cyc - last_lead;
                last_lead = cyc;
            end
            if (last_edge >= 0 && (cyc - last_edge) > max_gap) max_gap = cyc - last_edge;
            last_edge = cyc;
            if ((sclk_prev == b_cpol) != b_cpha) mon_bits = mon_bits + 1;
        end
        sclk_prev = spi_sclk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        min_per = 1000000; max_gap = 0; last_lead = -1; last_edge = -1;
        edges = 0; mon_bits = 0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [15:0] cw(input bit st);
        return {4'h0, b_lm, b_rate, st, b_cpha, b_cpol, b_ms, b_en};
    endfunction

    function automatic logic [15:0] lmask(input logic [3:0] lm);
        return 16'((17'h1 << (int'(lm) + 1)) - 1);
    endfunction

    task automatic setup(input bit en, input bit ms, input bit pol, input bit pha,
                         input logic [2:0] rt, input logic [3:0] lm);
        b_en = en; b_ms = ms; b_cpol = pol; b_cpha = pha; b_rate = rt; b_lm = lm;
        reg_write(3'd2, cw(1'b0));
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        int guard = 0;
        do begin
            reg_read(3'd2, v);
            guard++;
        end while (v[4] && guard < 20000);
    endtask

    task automatic xfer_check(input int n, input string req);
        logic [15:0] v;
        clear_mon();
        for (int i = 0; i < n; i++) reg_write(3'd0, wq[i]);
        reg_write(3'd2, cw(1'b1));
        reg_read(3'd2, v);
        chk(v[4] == 1'b1, "R3 start reads busy", v[4], 1);
        wait_idle();
        reg_read(3'd3, v);
        chk(v[0] == 1'b1, "R3 queue empty at clear", v[0], 1);
        chk(v[1] == 1'b1, "R10 rx ready", v[1], 1);
        chk(mon_bits == n * (int'(b_lm) + 1), "R6 sampling edges", mon_bits, n * (int'(b_lm) + 1));
        chk(spi_sclk == b_cpol, "R6 idle level", spi_sclk, b_cpol);
        for (int i = 0; i < n; i++) begin
            reg_read(3'd1, v);
            chk(v == (wq[i] & lmask(b_lm)), req, v, wq[i] & lmask(b_lm));
        end
        reg_read(3'd3, v);
        chk(v[1] == 1'b0, "R10 rx drained", v[1], 0);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        reg_read(3'd2, v);
        chk(v == 16'h07E0, "R1 ctrl reset", v, 16'h07E0);
        reg_read(3'd3, v);
        chk(v == 16'h0001, "R1 R10 status reset", v, 16'h0001);
        chk(spi_sclk == 1'b0, "R1 sclk reset", spi_sclk, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            setup(1, 1, m[1], m[0], 3'd0, 4'd7);
            chk(spi_sclk == m[1], "R6 polarity idle", spi_sclk, m[1]);
            wq[0] = 16'h00A5; wq[1] = 16'h003C;
            xfer_check(2, "R6 mode loopback");
        end
    endtask

    task automatic t_lengths();
        setup(1, 1, 0, 0, 3'd1, 4'd15);
        wq[0] = 16'hBEEF; wq[1] = 16'h1234;
        xfer_check(2, "R5 16-bit word");
        setup(1, 1, 1, 1, 3'd0, 4'd0);
        wq[0] = 16'h0001; wq[1] = 16'h0000; wq[2] = 16'h0003;
        xfer_check(3, "R5 1-bit word");
        setup(1, 1, 0, 1, 3'd0, 4'd3);
        wq[0] = 16'hFFFF; wq[1] = 16'h00A5;
        xfer_check(2, "R5 4-bit right aligned");
    endtask

    task automatic t_divider();
        for (int r = 0; r < 4; r += 3) begin
            setup(1, 1, 0, 0, 3'(r), 4'd7);
            wq[0] = 16'h0055;
            xfer_check(1, "R4 data");
            chk(min_per == (4 << r), "R4 sclk period", min_per, 4 << r);
        end
    endtask

    task automatic t_gap();
        int g0;
        setup(1, 1, 0, 0, 3'd0, 4'd7);
        reg_write(3'd5, 16'd0);
        wq[0] = 16'h00C3; wq[1] = 16'h003C;
        xfer_check(2, "R7 data no gap");
        g0 = max_gap;
        reg_write(3'd5, 16'd2);
        xfer_check(2, "R7 data with gap");
        chk((max_gap - g0) == 8, "R7 idle gap", max_gap - g0, 8);
        reg_write(3'd5, 16'd0);
    endtask

    task automatic t_enable();
        logic [15:0] v;
        setup(0, 1, 0, 0, 3'd0, 4'd7);
        clear_mon();
        reg_write(3'd0, 16'h005A);
        reg_write(3'd2, cw(1'b1));
        repeat (200) @(negedge clk);
        chk(edges == 0, "R8 no clock while disabled", edges, 0);
        reg_read(3'd3, v);
        chk(v[0] == 1'b0, "R8 word stays queued", v[0], 0);
        b_en = 1; b_ms = 0;
        reg_write(3'd2, cw(1'b1));
        repeat (200) @(negedge clk);
        chk(edges == 0, "R8 no clock without master", edges, 0);
        b_ms = 1;
        reg_write(3'd2, cw(1'b1));
        wait_idle();
        reg_read(3'd1, v);
        chk(v == 16'h005A, "R8 runs once enabled", v, 16'h005A);
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        setup(0, 1, 0, 0, 3'd0, 4'd7);
        for (int i = 0; i < 9; i++) reg_write(3'd0, 16'(8'h11 * (i + 1)));
        reg_read(3'd3, v);
        chk(v[3] == 1'b1, "R2 tx overflow flag", v[3], 1);
        reg_write(3'd3, 16'h0008);
        reg_read(3'd3, v);
        chk(v[3] == 1'b0, "R2 tx overflow cleared", v[3], 0);
        b_en = 1;
        reg_write(3'd2, cw(1'b1));
        wait_idle();
        reg_read(3'd3, v);
        chk(v[2] == 1'b0, "R9 no rx overflow at 8", v[2], 0);
        reg_write(3'd0, 16'h0099);
        reg_write(3'd2, cw(1'b1));
        wait_idle();
        reg_read(3'd3, v);
        chk(v[2] == 1'b1, "R9 rx overflow flag", v[2], 1);
        for (int i = 0; i < 8; i++) begin
            reg_read(3'd1, v);
            chk(v == 16'(8'h11 * (i + 1)), "R2 R9 surviving words", v, 8'h11 * (i + 1));
        end
        reg_read(3'd3, v);
        chk(v[1] == 1'b0, "R9 rx empty after 8 pops", v[1], 0);
        reg_write(3'd3, 16'h0004);
        reg_read(3'd3, v);
        chk(v[2] == 1'b0, "R9 rx overflow cleared", v[2], 0);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        reg_write(3'd4, 16'h0001);
        chk(irq == 1'b1, "R11 tx empty irq", irq, 1);
        reg_write(3'd4, 16'h0002);
        chk(irq == 1'b0, "R11 masked flag", irq, 0);
        setup(1, 1, 0, 0, 3'd0, 4'd7);
        reg_write(3'd0, 16'h0042);
        reg_write(3'd2, cw(1'b1));
        wait_idle();
        chk(irq == 1'b1, "R11 rx ready irq", irq, 1);
        reg_read(3'd1, v);
        chk(irq == 1'b0, "R11 irq drops after pop", irq, 0);
        reg_write(3'd4, 16'h0000);
    endtask

    task automatic t_concurrent();
        logic [15:0] v;
        setup(1, 1, 0, 0, 3'd0, 4'd0);
        clear_mon();
        for (int i = 0; i < 8; i++) wq[i] = 16'(16'h00FF * (i + 1));
        reg_write(3'd0, wq[0]);
        reg_write(3'd2, cw(1'b1));
        for (int i = 1; i < 8; i++) reg_write(3'd0, wq[i]);
        for (int k = 0; k < 8; k++) begin
            wait_idle();
            reg_read(3'd3, v);
            if (v[0]) break;
            reg_write(3'd2, cw(1'b1));
        end
        chk(mon_bits == 8, "R12 word count", mon_bits, 8);
        for (int i = 0; i < 8; i++) begin
            reg_read(3'd1, v);
            chk(v == (wq[i] & 16'h0001), "R12 order", v, wq[i] & 16'h0001);
        end
    endtask

    initial begin
        #750000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_modes();
        t_lengths();
        t_divider();
        t_gap();
        t_enable();
        t_overflow();
        t_irq();
        t_concurrent();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule